// File: doc/BRIEF.md
# Strap-Selected Bus Memory Module

This block is one memory module that sits on a single shared processor bus. The bus carries both addresses and data and has the same width as a memory word. The module has its own address register. A load-address command fills it from the bus. The low bits of that register index the local storage array. The top `SEL_W` bits pick the segment of the address space that the module owns. Three strap inputs, tied off at board or chip level, name the segment this instance answers.

A read command makes the module drive the bus with the addressed word. A store command writes the bus value into the addressed word on the rising clock edge. Both happen only while the address register's segment field equals the straps. Several modules with different straps can therefore share one bus without decode logic outside them. The bus is split into a data input, a data output and an output enable; an enable of zero stands for high impedance.

The full-size build sets `DATA_W = 16` and `SEL_W = 3`, which gives 13 index bits and 8K words of 16 bits. The default build uses `DATA_W = 11`, which gives 256 words per module, so that exhaustive sweeps stay short. The segment field is always the top `SEL_W` bits of the address word, and the index is the remaining low bits.

Top module: `bus_ram_module`

## Requirements
- R1: While `rst_ni` is low, the address register is cleared to zero. This is asynchronous. After reset, a module whose straps are 0 drives on a read, and modules with other straps do not.
- R2: On a rising edge with `ld_addr_i` high, the address register takes `bus_i`. With `ld_addr_i` low, it keeps its value whatever `bus_i` carries.
- R3: When `rd_i` is high and address bits `[DATA_W-1:DATA_W-SEL_W]` equal `strap_i`, `bus_oe_o` is 1. In that case `bus_o` carries the word indexed by address bits `[DATA_W-SEL_W-1:0]`. The output follows the address register combinationally, in the same cycle.
- R4: When `rd_i` is low or the segment field differs from `strap_i`, `bus_oe_o` is 0 and `bus_o` is all zeros.
- R5: On a rising edge with `st_i` high and a matching segment field, the indexed word takes `bus_i`.
- R6: On a rising edge with `st_i` high and a segment field that does not match, no stored word changes.
- R7: When `ld_addr_i` and `st_i` are both high on the same edge, the write goes to the address held before that edge. The address register then takes the bus value.
- R8: Two modules with different strap values never drive the bus together, for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes and address loads use the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | DATA_W | Value present on the shared bus |
| ld_addr_i | input | 1 | Load the address register from the bus |
| rd_i | input | 1 | Read command: drive the addressed word if selected |
| st_i | input | 1 | Store command: write the bus value if selected |
| strap_i | input | SEL_W | Tied-off segment number this module answers |
| bus_o | output | DATA_W | Read data towards the bus, zero when not driving |
| bus_oe_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
A wrong address register shows up at the ports in the first read cycle after the bad load. Either the wrong word appears on `bus_o`, or the drive enable takes the wrong state, because the segment compare also reads that register. A write lost or misdirected by the store gating stays invisible until that word is read again. The bench therefore fills every word of two segments, then reads every address in the whole space on two modules at once. A corrupted word or a drive enable that comes on together with the other module is caught at the latest in that final sweep.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef struct packed {
    logic ld;
    logic rd;
    logic st;
  } brm_cmd_t;

  function automatic int unsigned brm_idx_w(int unsigned data_w, int unsigned sel_w);
    return data_w - sel_w;
  endfunction

endpackage

// File: rtl/brm_addr_reg.sv
module brm_addr_reg #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/brm_select.sv
module brm_select #(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [DATA_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  strap_i,
  output logic              match_o
);

  localparam int unsigned TOP = DATA_W - 1;

  logic [SEL_W-1:0] bit_eq;

  // one equality term per strap bit
  for (genvar g = 0; g < SEL_W; g++) begin : g_cmp
    assign bit_eq[g] = ~(addr_i[TOP-SEL_W+1+g] ^ strap_i[g]);
  end

  assign match_o = &bit_eq;

endmodule

// File: rtl/brm_array.sv
module brm_array #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/brm_drive.sv
module brm_drive #(
  parameter int unsigned DATA_W = 11
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  assign bus_oe_o = en_i;
  assign bus_o    = en_i ? rdata_i : '0;

endmodule

// File: rtl/bus_ram_module.sv
module bus_ram_module
  import brm_pkg::*;
#(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              ld_addr_i,
  input  logic              rd_i,
  input  logic              st_i,
  input  logic [SEL_W-1:0]  strap_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  localparam int unsigned IDX_W = brm_idx_w(DATA_W, SEL_W);

  brm_cmd_t          cmd;
  logic [DATA_W-1:0] addr_q;
  logic              match;
  logic [DATA_W-1:0] rdata;

  assign cmd = '{ld: ld_addr_i, rd: rd_i, st: st_i};

  brm_addr_reg #(.W(DATA_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd.ld),
    .d_i    (bus_i),
    .q_o    (addr_q)
  );

  brm_select #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel (
    .addr_i  (addr_q),
    .strap_i (strap_i),
    .match_o (match)
  );

  // write index is the pre-edge address, so ld+st writes the old location
  brm_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (cmd.st & match),
    .idx_i   (addr_q[IDX_W-1:0]),
    .wdata_i (bus_i),
    .rdata_o (rdata)
  );

  brm_drive #(.DATA_W(DATA_W)) u_drv (
    .en_i     (cmd.rd & match),
    .rdata_i  (rdata),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o)
  );

endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] bus_i,
  input logic              ld_addr_i,
  input logic              rd_i,
  input logic              st_i,
  input logic [SEL_W-1:0]  strap_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] addr_q_i,
  input logic [DATA_W-1:0] rdata_i
);

  logic seg_eq;
  assign seg_eq = (addr_q_i[DATA_W-1 -: SEL_W] == strap_i);

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ADDR: assert (addr_q_i == '0); // R1
  end

  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_addr_i |=> addr_q_i == $past(bus_i)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_addr_i |=> $stable(addr_q_i)); // R2
  AST_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> bus_o == rdata_i); // R3
  AST_OE_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> rd_i); // R4
  AST_OE_NEEDS_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> seg_eq); // R4
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i && seg_eq && !ld_addr_i) |=> rdata_i == $past(bus_i)); // R5
  AST_FOREIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seg_eq && !ld_addr_i) |=> $stable(rdata_i)); // R6

endmodule

bind bus_ram_module brm_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_i     (bus_i),
  .ld_addr_i (ld_addr_i),
  .rd_i      (rd_i),
  .st_i      (st_i),
  .strap_i   (strap_i),
  .bus_o     (bus_o),
  .bus_oe_o  (bus_oe_o),
  .addr_q_i  (addr_q),
  .rdata_i   (rdata)
);

// File: tb/tb_bus_ram_module.sv
module tb_bus_ram_module;

  localparam int unsigned DW = 11;
  localparam int unsigned SW = 3;
  localparam int unsigned IW = DW - SW;
  localparam int unsigned NW = 1 << IW;
  localparam logic [SW-1:0] SEG_A = 3'd2;
  localparam logic [SW-1:0] SEG_B = 3'd0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] bus;
  logic          ld, rd, st;
  logic [DW-1:0] out_a, out_b;
  logic          oe_a, oe_b;
  bit            done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [DW-1:0] mdl_a [NW];
  logic [DW-1:0] mdl_b [NW];

  always #10 clk = ~clk;

  bus_ram_module #(.DATA_W(DW), .SEL_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .ld_addr_i(ld), .rd_i(rd), .st_i(st),
    .strap_i(SEG_A), .bus_o(out_a), .bus_oe_o(oe_a)
  );

  bus_ram_module #(.DATA_W(DW), .SEL_W(SW)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .ld_addr_i(ld), .rd_i(rd), .st_i(st),
    .strap_i(SEG_B), .bus_o(out_b), .bus_oe_o(oe_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic do_load(input logic [DW-1:0] a);
    bus = a; ld = 1'b1;
    tick();
    ld = 1'b0;
  endtask

  task automatic do_store(input logic [DW-1:0] d);
    bus = d; st = 1'b1;
    tick();
    st = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat_a(input int i);
    int v = (i * 37 + 5) ^ 16'h02AA;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] pat_b(input int i);
    int v = (i * 53 + 17) ^ 16'h0155;
    return v[DW-1:0];
  endfunction

  // checks both modules for the address currently held
  task automatic chk_read(input logic [DW-1:0] a);
    bit ea, eb;
    ea = (a[DW-1 -: SW] == SEG_A);
    eb = (a[DW-1 -: SW] == SEG_B);
    rd = 1'b1;
    #1;
    chk(oe_a == ea, ea ? "R3 oe_a" : "R4 oe_a", int'(oe_a), int'(ea));
    chk(oe_b == eb, eb ? "R3 oe_b" : "R4 oe_b", int'(oe_b), int'(eb));
    if (ea) chk(out_a == mdl_a[a[IW-1:0]], "R3 data_a", int'(out_a), int'(mdl_a[a[IW-1:0]]));
    else    chk(out_a == '0, "R4 zero_a", int'(out_a), 0);
    if (eb) chk(out_b == mdl_b[a[IW-1:0]], "R3 data_b", int'(out_b), int'(mdl_b[a[IW-1:0]]));
    else    chk(out_b == '0, "R4 zero_b", int'(out_b), 0);
    chk(!(oe_a && oe_b), "R8 contention", int'({oe_a, oe_b}), 0);
    rd = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus = '0; ld = 1'b0; rd = 1'b0; st = 1'b0;
    @(posedge clk); @(posedge clk); #5;
    // R1: reset address is zero, so only the segment-0 module answers
    #1;
    chk(!oe_a && !oe_b, "R1 idle", int'({oe_a, oe_b}), 0);
    rd = 1'b1; #1;
    chk(oe_b == 1'b1, "R1 seg0 drive", int'(oe_b), 1);
    chk(oe_a == 1'b0, "R1 seg2 quiet", int'(oe_a), 0);
    rd = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();

    // R5: fill both segments
    for (int i = 0; i < NW; i++) begin
      do_load({SEG_A, i[IW-1:0]});
      do_store(pat_a(i));
      mdl_a[i] = pat_a(i);
      do_load({SEG_B, i[IW-1:0]});
      do_store(pat_b(i));
      mdl_b[i] = pat_b(i);
    end

    // R6: stores to segments nobody owns change nothing
    for (int s = 1; s < 8; s++) begin
      if (s[SW-1:0] != SEG_A) begin
        for (int i = 0; i < NW; i += 17) begin
          do_load({s[SW-1:0], i[IW-1:0]});
          do_store(~pat_a(i));
        end
      end
    end
    for (int i = 0; i < NW; i += 17) begin
      do_load({SEG_A, i[IW-1:0]}); chk_read({SEG_A, i[IW-1:0]}); // R6 seg A intact
      do_load({SEG_B, i[IW-1:0]}); chk_read({SEG_B, i[IW-1:0]}); // R6 seg B intact
    end

    // R2: address holds while the bus moves without a load
    do_load({SEG_A, 8'd33});
    bus = {SEG_B, 8'd77};
    tick();
    bus = '1;
    tick();
    chk_read({SEG_A, 8'd33}); // R2 hold

    // R4: no drive without read even when selected
    #1;
    chk(!oe_a && out_a == '0, "R4 no rd", int'(out_a), 0);

    // R7: load and store together write the old location
    do_load({SEG_A, 8'd5});
    bus = {SEG_A, 8'd9}; ld = 1'b1; st = 1'b1;
    tick();
    ld = 1'b0; st = 1'b0;
    mdl_a[5] = {SEG_A, 8'd9};
    chk_read({SEG_A, 8'd9});  // R7 new address, word untouched
    do_load({SEG_A, 8'd5});
    chk_read({SEG_A, 8'd5});  // R7 old address got the value

    // R3 R4 R8: full sweep of the address space
    for (int a = 0; a < (1 << DW); a++) begin
      do_load(a[DW-1:0]);
      chk_read(a[DW-1:0]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule